// File: doc/BRIEF.md
# Status Register and Write Protection Unit

This block holds the 8-bit status byte of a small serial nonvolatile memory and decides which write-related commands take effect. Its inputs are decoded command events from the serial front end: write-enable set, write-enable clear, and the end of a status-write frame with its byte count and data byte. It also takes the busy state and completion pulse of the page writer and the active-low status lock pin. It reports the status byte, a protect-hit flag for a page address presented by the page writer, and the busy window of its own self-timed status write.

A two-bit protect code selects a fixed region at the top of the array: nothing, the upper quarter, the upper half, or everything. A one-bit lock flag in the status byte works together with the lock pin, and guards only the status byte itself. A status write lasts a parameterised number of cycles. While it runs, the ready/busy bit reads as busy. When it finishes, the write-enable latch clears itself. The nonvolatile bits are modelled as registers that load from parameters at reset, and the reset stands in for power-on.

Top module: `sr_guard`

## Requirements
- R1: After reset the status byte is {SRWP_INIT, 000, BP_INIT, 0, 0}, and sw_busy and prot_hit are 0.
- R2: The status byte layout is: bit0 ready/busy (1 = busy), bit1 write-enable latch, bits 3:2 protect code, bit7 lock flag. Bits 6:4 always read 0.
- R3: A cmd_wen_set pulse sets bit1 on the next edge, unless page_busy or sw_busy is high, in which case it is ignored. A cmd_wen_clr pulse always clears bit1, and it wins over a set in the same cycle.
- R4: A status frame is accepted only when all of these hold: sw_frame_bytes is 1, sw_frame_ragged is 0, bit1 is 1, and neither page_busy nor sw_busy is high. An accepted frame loads data bits 7, 3 and 2 into the lock flag and the protect code on the next edge. All other data bits are ignored.
- R5: When the lock flag is 1 and lock_n is low, a status frame is refused. When lock_n is high, the frame is accepted whatever the lock flag holds.
- R6: After an accepted frame, sw_busy is high for exactly PROG_CYC cycles, starting on the edge that accepts the frame. Bit0 reads 1 throughout.
- R7: Bit1 clears on the edge where sw_busy falls. It also clears on the edge after a page_done pulse.
- R8: A refused status frame leaves the whole status byte unchanged, including bit1, and does not start sw_busy.
- R9: Bit0 is 1 in the cycle after page_busy is high, and 0 when neither page_busy in the previous cycle nor sw_busy is high.
- R10: prot_hit, one cycle after chk_addr, reflects the protect code. Code 00 never hits. Code 01 hits when the two top address bits are 11 (6000h to 7FFFh for 15 bits). Code 10 hits when the top bit is 1. Code 11 always hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on model) |
| cmd_wen_set | input | 1 | Write-enable set command event (one cycle) |
| cmd_wen_clr | input | 1 | Write-enable clear command event (one cycle) |
| sw_frame_end | input | 1 | Status-write frame closed by chip-select rise (one cycle) |
| sw_frame_bytes | input | 2 | Complete data bytes in the frame, saturating at 2 |
| sw_frame_ragged | input | 1 | Frame ended with a partial byte |
| sw_frame_data | input | 8 | First data byte of the frame |
| lock_n | input | 1 | Status lock pin, low = lock asserted |
| page_busy | input | 1 | Page writer is programming |
| page_done | input | 1 | Page write completed (one cycle) |
| chk_addr | input | ADDR_W | Address to test against the protected region |
| status_byte | output | 8 | Status byte |
| prot_hit | output | 1 | chk_addr lies in the protected region (registered) |
| sw_busy | output | 1 | Self-timed status write in progress |

## Verification
On every cycle, the assertions check these behaviours:
- the reserved bits stay at zero;
- write-enable reacts to set, clear, page completion and the end of a status write;
- malformed and locked frames leave the lock flag and the protect code untouched;
- page_busy shows on the ready bit;
- codes 00 and 11 force prot_hit.

Other behaviours show only in the bench's scenarios:
- the exact length of the busy window;
- which data bits an accepted frame actually loads;
- refusal while busy;
- the pin-over-flag precedence of the lock;
- the region boundaries of codes 01 and 10, which the bench sweeps across the address space for every code.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SRWP_BIT = 7;
  localparam int BP_HI    = 3;
  localparam int BP_LO    = 2;

  typedef struct packed {
    logic       srwp;
    logic [2:0] rsvd;
    logic [1:0] bp;
    logic       wen;
    logic       rdy;
  } status_t;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_code_e;
endpackage

// File: rtl/sr_prog_timer.sv
module sr_prog_timer #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic fin
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  assign fin = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CYC);
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sr_wen_ctl.sv
module sr_wen_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic block,
  output logic wen
);
  always_ff @(posedge clk) begin
    if (rst)                     wen <= 1'b0;
    else if (clr_req)            wen <= 1'b0;
    else if (set_req && !block)  wen <= 1'b1;
  end
endmodule

// File: rtl/sr_prot_decode.sv
module sr_prot_decode import sr_pkg::*; #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic hit_d;

  always_comb begin
    case (prot_code_e'(bp))
      PROT_NONE:    hit_d = 1'b0;
      PROT_QUARTER: hit_d = &addr[ADDR_W-1:ADDR_W-2];
      PROT_HALF:    hit_d = addr[ADDR_W-1];
      default:      hit_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= hit_d;
  end
endmodule

// File: rtl/sr_guard.sv
module sr_guard import sr_pkg::*; #(
  parameter int         ADDR_W    = 15,
  parameter int         PROG_CYC  = 16,
  parameter logic [1:0] BP_INIT   = 2'b00,
  parameter logic       SRWP_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wen_set,
  input  logic              cmd_wen_clr,
  input  logic              sw_frame_end,
  input  logic [1:0]        sw_frame_bytes,
  input  logic              sw_frame_ragged,
  input  logic [7:0]        sw_frame_data,
  input  logic              lock_n,
  input  logic              page_busy,
  input  logic              page_done,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [7:0]        status_byte,
  output logic              prot_hit,
  output logic              sw_busy
);
  logic [1:0] bp_q;
  logic       srwp_q;
  logic       rdy_pg_q;
  logic       wen;
  logic       tmr_fin;
  logic       busy_any;
  logic       frame_ok;
  logic       unlocked;
  logic       accept;
  status_t    st;

  assign busy_any = page_busy | sw_busy;
  assign frame_ok = sw_frame_end && (sw_frame_bytes == 2'd1) && !sw_frame_ragged;
  assign unlocked = lock_n | ~srwp_q;
  assign accept   = frame_ok & wen & unlocked & ~busy_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q     <= BP_INIT;
      srwp_q   <= SRWP_INIT;
      rdy_pg_q <= 1'b0;
    end else begin
      rdy_pg_q <= page_busy;
      if (accept) begin
        bp_q   <= sw_frame_data[BP_HI:BP_LO];
        srwp_q <= sw_frame_data[SRWP_BIT];
      end
    end
  end

  sr_prog_timer #(.CYC(PROG_CYC)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .busy  (sw_busy),
    .fin   (tmr_fin)
  );

  sr_wen_ctl u_wen (
    .clk     (clk),
    .rst     (rst),
    .set_req (cmd_wen_set),
    .clr_req (cmd_wen_clr | page_done | tmr_fin),
    .block   (busy_any),
    .wen     (wen)
  );

  sr_prot_decode #(.ADDR_W(ADDR_W)) u_prot (
    .clk  (clk),
    .rst  (rst),
    .bp   (bp_q),
    .addr (chk_addr),
    .hit  (prot_hit)
  );

  assign st.srwp = srwp_q;
  assign st.rsvd = 3'b000;
  assign st.bp   = bp_q;
  assign st.wen  = wen;
  assign st.rdy  = rdy_pg_q | sw_busy;
  assign status_byte = st;
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_wen_set,
  input logic       cmd_wen_clr,
  input logic       sw_frame_end,
  input logic [1:0] sw_frame_bytes,
  input logic       lock_n,
  input logic       page_busy,
  input logic       page_done,
  input logic [7:0] status_byte,
  input logic       prot_hit,
  input logic       sw_busy
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_byte[6:4] == 3'b000); // R2
  AST_WEN_SET: assert property (@(posedge clk) disable iff (rst)
    (cmd_wen_set && !cmd_wen_clr && !page_busy && !sw_busy && !page_done) |=> status_byte[1]); // R3
  AST_WEN_CLR: assert property (@(posedge clk) disable iff (rst)
    cmd_wen_clr |=> !status_byte[1]); // R3
  AST_FRAME_BAD: assert property (@(posedge clk) disable iff (rst)
    (sw_frame_end && sw_frame_bytes != 2'd1) |=> $stable(status_byte[7:2])); // R4
  AST_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (sw_frame_end && status_byte[7] && !lock_n) |=> $stable(status_byte[7:2])); // R5
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_busy) |-> $past(sw_frame_end)); // R6
  AST_SW_DONE_WEN: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_busy) |-> !status_byte[1]); // R7
  AST_PAGE_DONE_WEN: assert property (@(posedge clk) disable iff (rst)
    page_done |=> !status_byte[1]); // R7
  AST_PAGE_RDY: assert property (@(posedge clk) disable iff (rst)
    page_busy |=> status_byte[0]); // R9
  AST_PROT_ALL: assert property (@(posedge clk) disable iff (rst)
    (status_byte[3:2] == 2'b11) |=> prot_hit); // R10
  AST_PROT_NONE: assert property (@(posedge clk) disable iff (rst)
    (status_byte[3:2] == 2'b00) |=> !prot_hit); // R10
endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .cmd_wen_set    (cmd_wen_set),
  .cmd_wen_clr    (cmd_wen_clr),
  .sw_frame_end   (sw_frame_end),
  .sw_frame_bytes (sw_frame_bytes),
  .lock_n         (lock_n),
  .page_busy      (page_busy),
  .page_done      (page_done),
  .status_byte    (status_byte),
  .prot_hit       (prot_hit),
  .sw_busy        (sw_busy)
);

// File: tb/sr_guard_bench.sv
module sr_guard_bench;
  localparam int AW  = 15;
  localparam int CYC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_wen_set = 1'b0;
  logic          cmd_wen_clr = 1'b0;
  logic          sw_frame_end = 1'b0;
  logic [1:0]    sw_frame_bytes = 2'd0;
  logic          sw_frame_ragged = 1'b0;
  logic [7:0]    sw_frame_data = 8'h00;
  logic          lock_n = 1'b1;
  logic          page_busy = 1'b0;
  logic          page_done = 1'b0;
  logic [AW-1:0] chk_addr = '0;
  logic [7:0]    status_byte;
  logic          prot_hit;
  logic          sw_busy;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sr_guard #(.ADDR_W(AW), .PROG_CYC(CYC), .BP_INIT(2'b00), .SRWP_INIT(1'b0)) u_sr_guard (
    .clk(clk), .rst(rst), .cmd_wen_set(cmd_wen_set), .cmd_wen_clr(cmd_wen_clr),
    .sw_frame_end(sw_frame_end), .sw_frame_bytes(sw_frame_bytes),
    .sw_frame_ragged(sw_frame_ragged), .sw_frame_data(sw_frame_data),
    .lock_n(lock_n), .page_busy(page_busy), .page_done(page_done),
    .chk_addr(chk_addr), .status_byte(status_byte), .prot_hit(prot_hit), .sw_busy(sw_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wen_set();
    @(negedge clk); cmd_wen_set = 1'b1;
    @(negedge clk); cmd_wen_set = 1'b0;
  endtask

  task automatic wen_clr();
    @(negedge clk); cmd_wen_clr = 1'b1;
    @(negedge clk); cmd_wen_clr = 1'b0;
  endtask

  task automatic frame(input logic [7:0] d, input logic [1:0] nb, input logic rg);
    @(negedge clk);
    sw_frame_end = 1'b1; sw_frame_bytes = nb; sw_frame_ragged = rg; sw_frame_data = d;
    @(negedge clk);
    sw_frame_end = 1'b0; sw_frame_bytes = 2'd0; sw_frame_ragged = 1'b0; sw_frame_data = 8'h00;
  endtask

  task automatic set_code(input logic [1:0] code);
    wen_set();
    frame({6'b000000, 2'b00} | {4'b0000, code, 2'b00}, 2'd1, 1'b0);
    repeat (CYC) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", status_byte, 8'h00);
    chk("R1 reset sw_busy", sw_busy, 0);
    chk("R1 reset prot_hit", prot_hit, 0);

    // R8/R4: frame without write enable is refused
    frame(8'hFF, 2'd1, 1'b0);
    chk("R4 no-wen frame status", status_byte, 8'h00);
    chk("R8 no-wen frame busy", sw_busy, 0);

    // R3 set / clear
    wen_set();
    chk("R3 set wen", status_byte, 8'h02);
    wen_clr();
    chk("R3 clear wen", status_byte, 8'h00);
    wen_set();
    chk("R3 set wen again", status_byte, 8'h02);

    // R4 malformed frames
    frame(8'h8C, 2'd2, 1'b0);
    chk("R4 two-byte frame", status_byte, 8'h02);
    chk("R8 two-byte busy", sw_busy, 0);
    frame(8'h8C, 2'd1, 1'b1);
    chk("R4 ragged frame", status_byte, 8'h02);
    frame(8'h8C, 2'd0, 1'b0);
    chk("R4 empty frame", status_byte, 8'h02);

    // R2/R4/R6/R7 accepted write: reserved and rdy/wen data bits ignored
    frame(8'h77, 2'd1, 1'b0);
    chk("R2 accepted layout", status_byte, 8'h07);
    for (int i = 0; i < CYC; i++) begin
      if (i > 0) @(negedge clk);
      chk("R6 busy window", sw_busy, 1);
      chk("R6 rdy during write", status_byte[0], 1);
    end
    @(negedge clk);
    chk("R6 busy ends", sw_busy, 0);
    chk("R7 wen cleared at end", status_byte, 8'h04);

    // R10 sweep over all codes
    for (int code = 0; code < 4; code++) begin
      set_code(code[1:0]);
      chk("R4 code loaded", status_byte, {4'b0000, code[1:0], 2'b00});
      for (int k = 0; k < (1 << AW) / 16; k++) begin
        for (int j = 0; j < 2; j++) begin
          int a;
          logic e;
          a = k * 16 + j * 15;
          case (code)
            0: e = 1'b0;
            1: e = (a >= 24576);
            2: e = (a >= 16384);
            default: e = 1'b1;
          endcase
          @(negedge clk); chk_addr = a[AW-1:0];
          @(negedge clk);
          chk("R10 protect decode", prot_hit, e);
        end
      end
    end
    // status now 0x0C

    // R5 lock flag and pin
    lock_n = 1'b1;
    wen_set();
    frame(8'h80, 2'd1, 1'b0);
    chk("R5 lock flag written", status_byte, 8'h83);
    repeat (CYC) @(negedge clk);
    chk("R5 lock flag settled", status_byte, 8'h80);
    wen_set();
    lock_n = 1'b0;
    frame(8'h0C, 2'd1, 1'b0);
    chk("R5 locked refusal", status_byte, 8'h82);
    chk("R8 locked no busy", sw_busy, 0);
    lock_n = 1'b1;
    frame(8'h0C, 2'd1, 1'b0);
    chk("R5 pin high overrides flag", status_byte, 8'h0F);
    repeat (CYC) @(negedge clk);
    chk("R7 wen cleared after status write", status_byte, 8'h0C);

    // R9 / R3 / R4 with page writer busy
    @(negedge clk); page_busy = 1'b1;
    @(negedge clk);
    chk("R9 rdy follows page_busy", status_byte[0], 1);
    wen_set();
    chk("R3 set ignored while busy", status_byte[1], 0);
    @(negedge clk); page_busy = 1'b0;
    @(negedge clk);
    chk("R9 rdy drops", status_byte[0], 0);
    wen_set();
    @(negedge clk); page_busy = 1'b1;
    frame(8'h00, 2'd1, 1'b0);
    chk("R4 frame refused while page busy", status_byte[7:1], 7'h07);
    chk("R8 no status busy while page busy", sw_busy, 0);
    @(negedge clk); page_done = 1'b1; page_busy = 1'b0;
    @(negedge clk); page_done = 1'b0;
    chk("R7 page_done clears wen", status_byte[1], 0);

    // R3 clear wins over set
    wen_set();
    @(negedge clk); cmd_wen_set = 1'b1; cmd_wen_clr = 1'b1;
    @(negedge clk); cmd_wen_set = 1'b0; cmd_wen_clr = 1'b0;
    chk("R3 clear wins", status_byte, 8'h0C);

    // R1 reset restores init values
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 reset reloads", status_byte, 8'h00);

    finish_run();
  end
endmodule